// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a parallel set of signed 24-bit audio samples into a serial bit stream for a digital audio receiver. Each bit period has one bit clock cycle. A frame clock marks where each sample period begins and which channel is being carried. Four framings are available: two-channel left-justified, two-channel right-justified, two-channel I2S, and a one-line framing that carries six channels on the single data line. Every sample goes out in two's complement with the most significant bit first.

All logic runs on one system clock. In master mode the block divides that clock to make the bit clock and the frame clock and drives both out. In slave mode it oversamples an external bit clock and frame clock through synchronizers and keeps its bit position locked to the frame-start edge of the external frame clock. The whole sample array is copied into a holding register as each frame begins. The user may therefore rewrite the sample input at any time, and the frame already on the line is not disturbed.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rst_n` is low, `sdata`, `bclk_out` and `lrck_out` are all 0.
- R2: In master mode (`cfg_master`=1), `bclk_out` has a period of 2*CLK_DIV system clocks. `sdata` and `lrck_out` change only on the system clock edge where `bclk_out` falls, so a receiver can sample them on the rising edge.
- R3: With `cfg_format`=0 (left-justified), a frame is 64 bit clocks. `lrck_out` is 1 for the first 32 bits, which carry channel 0, and 0 for the last 32 bits, which carry channel 1. The channel MSB sits in the first bit of its half, the rest follow MSB first, and bits 24..31 of each half are 0.
- R4: With `cfg_format`=1 (right-justified), the frame clock is the same as in R3. Bits 0..7 of each 32-bit half are 0, and the sample LSB is in bit 31 of the half.
- R5: With `cfg_format`=2 (I2S), a frame is 64 bit clocks. `lrck_out` is 0 for the first half (channel 0) and 1 for the second half (channel 1). Each MSB is sent one bit clock after the frame clock changes. Bits that fall outside a 24-bit sample are 0.
- R6: With `cfg_format`=3 (one-line), a frame is 192 bit clocks, made of six 32-bit slots. Slot k carries channel k, left-justified (MSB in the slot's first bit, the last 8 bits 0). `lrck_out` is 1 during slots 0..2 and 0 during slots 3..5.
- R7: Channel k is taken from `sample_in[24k+23:24k]`. The whole input is captured at the first bit of a frame, so a change made during a frame first appears in the next frame.
- R8: In slave mode (`cfg_master`=0), bits advance on the falling edges of `bclk_in`. The bit position is forced to frame start at the start edge of `lrck_in`: a rising edge for formats 0, 1 and 3, a falling edge for format 2. The stream is correct from the first full frame after that edge. `bclk_out` and `lrck_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the clocks; 0: follow external clocks |
| cfg_format | input | 2 | 0 left-justified, 1 right-justified, 2 I2S, 3 one-line |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External frame clock (slave mode) |
| sample_in | input | 144 | Six 24-bit signed samples; channel k at bits 24k+23..24k |
| bclk_out | output | 1 | Generated bit clock (master mode), else 0 |
| lrck_out | output | 1 | Generated frame clock (master mode), else 0 |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bound assertions check, on every cycle, the properties that depend on only one cycle or one edge. These are: data and frame clock move only when the bit clock falls, the zero padding sits in the right slot positions for left-justified, right-justified and one-line framing, the I2S frame clock is low in the left half, a sample capture is followed by bit position zero, and the clock outputs stay silent in slave mode. Some behaviours cover a whole frame, and only the bench scenarios can show them. These are the exact bit order of each sample in every format, the one-bit I2S delay, holding the old samples when `sample_in` changes mid-frame, and recovery from a slave stream that starts at an arbitrary bit position and must lock onto the next frame-start edge.

// File: rtl/atx_pkg.sv
package atx_pkg;

  // Framing selector; the code values are part of the port contract.
  typedef enum logic [1:0] {
    FMT_LEFT    = 2'd0,
    FMT_RIGHT   = 2'd1,
    FMT_I2S     = 2'd2,
    FMT_ONELINE = 2'd3
  } atx_fmt_e;

endpackage

// File: rtl/atx_clk_master.sv
// Divides the system clock into a bit clock and flags the cycle in which it falls.
module atx_clk_master #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic fall_tick
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             half_done;

  assign half_done = (div_q == DIV_LAST);
  // The serializer advances on the same edge that drives bclk low.
  assign fall_tick = en && bclk && half_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bclk  <= 1'b0;
    end else if (!en) begin
      div_q <= '0;
      bclk  <= 1'b0;
    end else if (half_done) begin
      div_q <= '0;
      bclk  <= ~bclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/atx_clk_slave.sv
// Brings the external bit and frame clocks into the system clock domain and
// reports bit-clock falls and frame-start edges.
module atx_clk_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_on_fall,
  input  logic bclk_in,
  input  logic lrck_in,
  output logic fall_tick,
  output logic start_edge
);
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS:0]   bsync_q;
  logic [SS-1:0] lsync_q;
  logic          lr_prev_q;
  logic          b_lvl, b_old, l_lvl, rise_tick;

  assign b_lvl = bsync_q[SS-1];
  assign b_old = bsync_q[SS];
  assign l_lvl = lsync_q[SS-1];

  assign fall_tick = en && b_old && !b_lvl;
  assign rise_tick = en && !b_old && b_lvl;
  // The frame clock is read at rising bit-clock edges, where it is stable.
  assign start_edge = rise_tick &&
                      (start_on_fall ? (lr_prev_q && !l_lvl) : (!lr_prev_q && l_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q   <= '0;
      lsync_q   <= '0;
      lr_prev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[SS-1:0], bclk_in};
      lsync_q <= {lsync_q[SS-2:0], lrck_in};
      if (rise_tick) lr_prev_q <= l_lvl;
    end
  end
endmodule

// File: rtl/atx_serializer.sv
// Bit position counter, per-frame sample capture and bit selection for all framings.
module atx_serializer
  import atx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int CHANNELS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  atx_fmt_e            fmt,
  input  logic                fall_tick,
  input  logic                start_edge,
  input  logic [CHANNELS*SAMPLE_W-1:0] sample_in,
  output logic                sdata,
  output logic                lrck,
  output logic [$clog2(CHANNELS*SLOT_W+1)-1:0] pos,
  output logic                frame_load
);
  localparam int STD_LEN = 2 * SLOT_W;
  localparam int OL_LEN  = CHANNELS * SLOT_W;
  localparam int POS_W   = $clog2(OL_LEN + 1);
  localparam int PCM_W   = CHANNELS * SAMPLE_W;
  localparam int PAD_W   = SLOT_W - SAMPLE_W;

  function automatic int frame_len(atx_fmt_e f);
    return (f == FMT_ONELINE) ? OL_LEN : STD_LEN;
  endfunction

  // Frame clock level for a bit position.
  function automatic logic frame_lrck(atx_fmt_e f, logic [POS_W-1:0] p);
    logic first_half;
    first_half = int'(p) < (frame_len(f) / 2);
    return (f == FMT_I2S) ? !first_half : first_half;
  endfunction

  // Data bit for a bit position, taken from a captured sample array.
  function automatic logic frame_bit(atx_fmt_e f, logic [POS_W-1:0] p,
                                     logic [PCM_W-1:0] pcm);
    int idx, ch, q, sel;
    logic [PCM_W-1:0] sh;
    idx = int'(p);
    if (f == FMT_I2S) idx = (idx == 0) ? STD_LEN - 1 : idx - 1;
    ch = idx / SLOT_W;
    q  = idx % SLOT_W;
    if (ch >= CHANNELS) return 1'b0;
    if (f == FMT_RIGHT) begin
      if (q < PAD_W) return 1'b0;
      sel = SLOT_W - 1 - q;
    end else begin
      if (q >= SAMPLE_W) return 1'b0;
      sel = SAMPLE_W - 1 - q;
    end
    sh = pcm >> (ch * SAMPLE_W + sel);
    return sh[0];
  endfunction

  logic [PCM_W-1:0] shadow_q;
  logic [POS_W-1:0] pos_nxt;
  logic             wrap, resync;

  assign wrap    = int'(pos) >= frame_len(fmt) - 1;
  assign pos_nxt = wrap ? '0 : pos + 1'b1;
  // Realign only when the external frame start disagrees with the counter.
  assign resync     = start_edge && (pos != '0);
  assign frame_load = resync || (fall_tick && wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '1;
      shadow_q <= '0;
      sdata    <= 1'b0;
      lrck     <= 1'b0;
    end else if (resync) begin
      pos      <= '0;
      shadow_q <= sample_in;
      sdata    <= frame_bit(fmt, '0, sample_in);
      lrck     <= frame_lrck(fmt, '0);
    end else if (fall_tick) begin
      pos   <= pos_nxt;
      sdata <= frame_bit(fmt, pos_nxt, wrap ? sample_in : shadow_q);
      lrck  <= frame_lrck(fmt, pos_nxt);
      if (wrap) shadow_q <= sample_in;
    end
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import atx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int CHANNELS    = 6,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_master,
  input  logic [1:0]                   cfg_format,
  input  logic                         bclk_in,
  input  logic                         lrck_in,
  input  logic [CHANNELS*SAMPLE_W-1:0] sample_in,
  output logic                         bclk_out,
  output logic                         lrck_out,
  output logic                         sdata
);
  localparam int POS_W = $clog2(CHANNELS * SLOT_W + 1);

  atx_fmt_e         fmt;
  logic             m_bclk, m_fall, s_fall, s_start;
  logic             fall_tick, start_edge, ser_lrck;
  logic [POS_W-1:0] bit_pos;
  logic             frame_load;

  assign fmt = atx_fmt_e'(cfg_format);

  atx_clk_master #(.CLK_DIV(CLK_DIV)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(cfg_master),
    .bclk(m_bclk), .fall_tick(m_fall)
  );

  atx_clk_slave #(.SYNC_STAGES(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst_n(rst_n), .en(!cfg_master),
    .start_on_fall(fmt == FMT_I2S),
    .bclk_in(bclk_in), .lrck_in(lrck_in),
    .fall_tick(s_fall), .start_edge(s_start)
  );

  assign fall_tick  = cfg_master ? m_fall : s_fall;
  assign start_edge = cfg_master ? 1'b0 : s_start;

  atx_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .CHANNELS(CHANNELS)) u_ser (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .fall_tick(fall_tick), .start_edge(start_edge),
    .sample_in(sample_in),
    .sdata(sdata), .lrck(ser_lrck), .pos(bit_pos), .frame_load(frame_load)
  );

  assign bclk_out = m_bclk;
  assign lrck_out = cfg_master && ser_lrck;
endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic [1:0]       cfg_format,
  input logic             bclk_out,
  input logic             lrck_out,
  input logic             sdata,
  input logic [POS_W-1:0] bit_pos,
  input logic             frame_load
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!sdata && !bclk_out && !lrck_out) else $error("outputs active in reset"); // R1
    end
  end

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !$stable(sdata) |-> $past(bclk_out) && !bclk_out); // R2

  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !$stable(lrck_out) |-> $past(bclk_out) && !bclk_out); // R2

  AST_LJ_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_format == 2'd0 || cfg_format == 2'd3) && (int'(bit_pos) % SLOT_W >= SAMPLE_W)
    |-> !sdata); // R3

  AST_RJ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_format == 2'd1) && (int'(bit_pos) % SLOT_W < SLOT_W - SAMPLE_W)
    |-> !sdata); // R4

  AST_I2S_LEFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && (cfg_format == 2'd2) && (int'(bit_pos) < SLOT_W) |-> !lrck_out); // R5

  AST_LOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (bit_pos == '0)); // R7

  AST_SLAVE_CLOCKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !bclk_out && !lrck_out); // R8
endmodule

bind audio_serial_tx atx_checker #(
  .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W($clog2(CHANNELS * SLOT_W + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_format(cfg_format),
  .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata(sdata),
  .bit_pos(bit_pos), .frame_load(frame_load)
);

// File: tb/audio_serial_tx_tb.sv
`timescale 1ns/1ps
module audio_serial_tx_tb;
  localparam int CLK_DIV = 4;
  localparam int SHALF   = 6;   // slave bit-clock half period, in system clocks

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_master = 1'b1;
  logic [1:0]   cfg_format = 2'd0;
  logic         bclk_in = 1'b0;
  logic         lrck_in = 1'b0;
  logic [143:0] sample_in = '0;
  logic         bclk_out, lrck_out, sdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [143:0] pcm_pend, pcm_cur;

  always #2 clk = ~clk;

  audio_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_format(cfg_format),
    .bclk_in(bclk_in), .lrck_in(lrck_in), .sample_in(sample_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata(sdata)
  );

  // Expected frame built as one MSB-first vector per format.
  function automatic logic exp_bit(int fmt, int p, logic [143:0] pcm);
    logic [23:0]  c [6];
    logic [191:0] v, t;
    for (int i = 0; i < 6; i++) c[i] = pcm[i*24 +: 24];
    case (fmt)
      0: v = {c[0], 8'h0, c[1], 8'h0, 128'h0};
      1: v = {8'h0, c[0], 8'h0, c[1], 128'h0};
      2: v = {1'b0, c[0], 8'h0, c[1], 7'h0, 128'h0};
      default: v = {c[0], 8'h0, c[1], 8'h0, c[2], 8'h0, c[3], 8'h0, c[4], 8'h0, c[5], 8'h0};
    endcase
    t = v << p;
    return t[191];
  endfunction

  function automatic int flen(int fmt);
    return (fmt == 3) ? 192 : 64;
  endfunction

  function automatic logic exp_lrck(int fmt, int p);
    logic left;
    left = p < flen(fmt) / 2;
    return (fmt == 2) ? !left : left;
  endfunction

  function automatic logic [143:0] rand_pcm();
    logic [143:0] r;
    for (int i = 0; i < 6; i++) r[i*24 +: 24] = 24'($urandom());
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string fmt_tag(int fmt, int p);
    if (p > flen(fmt) / 2) return "R7";
    case (fmt)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic do_reset(input logic master, input int fmt);
    rst_n = 1'b0;
    cfg_master = master;
    cfg_format = 2'(fmt);
    bclk_in = 1'b0;
    lrck_in = 1'b0;
    // Directed corner samples: full negative, full positive, zero, -1, +1, alternating.
    sample_in = {24'h555555, 24'h000001, 24'hFFFFFF, 24'h000000, 24'h7FFFFF, 24'h800000};
    if (fmt == 1) sample_in = rand_pcm();
    pcm_pend = sample_in;
    pcm_cur = '0;
    repeat (5) @(posedge clk);
    #1;
    check("R1 sdata", sdata, 1'b0);
    check("R1 bclk_out", bclk_out, 1'b0);
    check("R1 lrck_out", lrck_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input int fmt, input int frames);
    int   n;
    realtime t_prev;
    n = flen(fmt);
    do_reset(1'b1, fmt);
    @(negedge bclk_out);
    t_prev = 0;
    for (int k = 0; k < frames * n; k++) begin
      int p;
      p = k % n;
      @(posedge bclk_out);
      if (k > 0) begin
        checks++;
        if ($realtime - t_prev != 2.0 * CLK_DIV * 4.0) begin
          errors++;
          $display("FAIL R2: bclk period %0t expected %0d", $realtime - t_prev, 2 * CLK_DIV * 4);
        end
      end
      t_prev = $realtime;
      #1;
      if (p == 0) pcm_cur = pcm_pend;
      check(fmt_tag(fmt, p), sdata, exp_bit(fmt, p, pcm_cur));
      check("R2 lrck", lrck_out, exp_lrck(fmt, p));
      if (p == n / 2) begin
        sample_in = rand_pcm();
        pcm_pend = sample_in;
      end
    end
  endtask

  // Slave stream starts at bit 'off' of a frame to force realignment.
  task automatic run_slave(input int fmt, input int frames, input int off);
    int n;
    n = flen(fmt);
    do_reset(1'b0, fmt);
    for (int k = 0; k < frames * n - off; k++) begin
      int p, f;
      p = (k + off) % n;
      f = (k + off) / n;
      @(negedge clk);
      bclk_in = 1'b0;
      lrck_in = exp_lrck(fmt, p);
      repeat (SHALF) @(negedge clk);
      bclk_in = 1'b1;
      if (p == 0) pcm_cur = pcm_pend;
      if (f >= 2) begin
        check({"R8 ", fmt_tag(fmt, p)}, sdata, exp_bit(fmt, p, pcm_cur));
        check("R8 bclk_out", bclk_out, 1'b0);
        check("R8 lrck_out", lrck_out, 1'b0);
      end
      if (p == n / 2) begin
        sample_in = rand_pcm();
        pcm_pend = sample_in;
      end
      repeat (SHALF - 1) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int fmt = 0; fmt < 4; fmt++) run_master(fmt, 3);
    for (int fmt = 0; fmt < 4; fmt++) run_slave(fmt, 4, 5 + fmt);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule